// File: doc/BRIEF.md
# System Clock Source Switch Controller

This controller picks the clock source that drives the system clock when a power-mode manager asks for a change. Each request carries a 4-bit source code and a 3-bit target mode. The request takes effect only when the chosen source reports that it is stable and the required start-up handshakes have completed. Until then the system keeps running on the source it already has.

The controller reports the source currently in use as a 4-bit status code. It also drives a one-hot select vector into a glitch-free clock multiplexer, and that vector is all zero when the clock is off. A single slot holds one request that arrives while a switch is still in progress.

Source codes: 0 = fast internal RC, 1 = divided internal RC, 2 = external crystal, 3 = divided crystal, 4 = PLL, 15 = clock disabled. Codes 5 to 14 are reserved.

Mode codes: 0 = reset, 1 = test, 2 = safe, 3 = drun, 4 = run, 5 = halt, 6 = stop, 7 = standby.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: After a synchronous reset, `cur_src` is 0 (internal RC), `busy` is 0 and `src_sel` is 5'b00001.
- R2: A switch to code 0 or 1 completes only on a clock edge where `irc_stable` is 1.
- R3: A switch to code 2 or 3 completes only on a clock edge where `xosc_stable` is 1.
- R4: A switch to code 4 completes only on an edge where both `pll_stable` and `pll_on_done` are 1.
- R5: No switch to any source completes on an edge where `periph_off_done` is 0.
- R6: If the target's stable flag was 0 on the edge the request was taken up, the switch also waits for `src_on_done` to be 1.
- R7: While a switch is pending, `cur_src` and `src_sel` keep the previous source.
- R8: `busy` rises on the edge after an accepted request. On the edge where the switch conditions hold, `cur_src` takes the new code and, if nothing is queued, `busy` falls.
- R9: Code 15 requested with mode 6 (stop) or mode 1 (test) is honoured. `cur_src` becomes 15 and `src_sel` becomes all zero.
- R10: Code 15 requested with any other mode (except standby) is ignored. `busy` stays 0 and `cur_src` is unchanged.
- R11: Reserved codes 5 to 14 are ignored in every mode other than standby. `busy` stays 0 and `cur_src` is unchanged.
- R12: A request with mode 7 (standby) leaves `cur_src` unchanged and forces `src_sel` to all zero. This lasts until a later switch with a non-standby mode completes.
- R13: A valid request that arrives while `busy` is 1 is held in one slot, where a later request replaces an earlier one. It is served after the current switch completes, and `busy` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_src | input | 4 | Requested source code |
| req_mode | input | 3 | Target mode code |
| irc_stable | input | 1 | Internal RC oscillator stable |
| xosc_stable | input | 1 | Crystal oscillator stable |
| pll_stable | input | 1 | PLL locked and stable |
| src_on_done | input | 1 | Source switch-on process finished |
| pll_on_done | input | 1 | PLL switch-on process finished |
| periph_off_done | input | 1 | Peripheral clock disable process finished |
| cur_src | output | 4 | Code of the source currently in use |
| src_sel | output | 5 | One-hot mux select; all zero when the clock is off or in standby |
| busy | output | 1 | A switch is in progress or queued |

## Verification
On every cycle, assertions check the following:
- a change of `cur_src` always follows an edge where the target's stable flag, the PLL handshake and the peripheral handshake were all set;
- the status holds while the controller waits;
- reserved codes never raise `busy`;
- the select vector is empty whenever standby is in force.

Three behaviours can only be shown by the bench's scenarios:
- that a source needing switch-on waits for `src_on_done`;
- that a queued request replaces an older queued one and is served next;
- that leaving standby restores the select vector.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int SRC_W   = 4;
    localparam int MODE_W  = 3;
    localparam int NUM_SRC = 5;

    localparam logic [SRC_W-1:0] SRC_IRC      = 4'd0;
    localparam logic [SRC_W-1:0] SRC_IRC_DIV  = 4'd1;
    localparam logic [SRC_W-1:0] SRC_XOSC     = 4'd2;
    localparam logic [SRC_W-1:0] SRC_XOSC_DIV = 4'd3;
    localparam logic [SRC_W-1:0] SRC_PLL      = 4'd4;
    localparam logic [SRC_W-1:0] SRC_OFF      = 4'd15;

    localparam logic [MODE_W-1:0] MD_TEST    = 3'd1;
    localparam logic [MODE_W-1:0] MD_STOP    = 3'd6;
    localparam logic [MODE_W-1:0] MD_STANDBY = 3'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sw_state_e;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [MODE_W-1:0] mode;
    } clk_req_t;

    function automatic logic req_is_legal(input clk_req_t r);
        if (r.mode == MD_STANDBY)
            return 1'b1;
        if (r.src <= SRC_PLL)
            return 1'b1;
        if (r.src == SRC_OFF)
            return (r.mode == MD_STOP) || (r.mode == MD_TEST);
        return 1'b0;
    endfunction

    function automatic logic src_is_stable(input logic [SRC_W-1:0] s,
                                           input logic irc,
                                           input logic xosc,
                                           input logic pll);
        case (s)
            SRC_IRC, SRC_IRC_DIV:   return irc;
            SRC_XOSC, SRC_XOSC_DIV: return xosc;
            SRC_PLL:                return pll;
            default:                return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sysclk_req_filter.sv
module sysclk_req_filter
    import sysclk_pkg::*;
(
    input  logic     req_valid,
    input  clk_req_t req,
    output logic     accept
);
    always_comb begin
        accept = req_valid && req_is_legal(req);
    end
endmodule

// File: rtl/sysclk_ready_eval.sv
module sysclk_ready_eval
    import sysclk_pkg::*;
(
    input  clk_req_t act,
    input  logic     need_on,
    input  logic     irc_stable,
    input  logic     xosc_stable,
    input  logic     pll_stable,
    input  logic     src_on_done,
    input  logic     pll_on_done,
    input  logic     periph_off_done,
    output logic     ready
);
    logic target_ok;
    logic on_ok;
    logic pll_ok;

    always_comb begin
        target_ok = src_is_stable(act.src, irc_stable, xosc_stable, pll_stable);
        on_ok     = !need_on || src_on_done;
        pll_ok    = (act.src != SRC_PLL) || pll_on_done;
        if (act.mode == MD_STANDBY)
            ready = 1'b1;
        else
            ready = periph_off_done && target_ok && on_ok && pll_ok;
    end
endmodule

// File: rtl/sysclk_sel_decode.sv
module sysclk_sel_decode
    import sysclk_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [SRC_W-1:0] cur_src,
    input  logic             stby,
    output logic [N_SRC-1:0] sel
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_sel
        assign sel[i] = !stby && (cur_src == SRC_W'(i));
    end
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [SRC_W-1:0]   req_src,
    input  logic [MODE_W-1:0]  req_mode,
    input  logic               irc_stable,
    input  logic               xosc_stable,
    input  logic               pll_stable,
    input  logic               src_on_done,
    input  logic               pll_on_done,
    input  logic               periph_off_done,
    output logic [SRC_W-1:0]   cur_src,
    output logic [NUM_SRC-1:0] src_sel,
    output logic               busy
);
    clk_req_t   req_in;
    clk_req_t   act_q;
    clk_req_t   pend_q;
    logic       pend_v_q;
    logic       need_on_q;
    logic       stby_q;
    sw_state_e  state_q;
    logic       accept;
    logic       ready;
    logic       req_need_on;
    logic       pend_need_on;

    assign req_in = '{src: req_src, mode: req_mode};
    assign busy   = (state_q == ST_WAIT);

    // A source whose stable flag is low when the request is taken up
    // must first be brought up by the switch-on process.
    assign req_need_on  = !src_is_stable(req_src, irc_stable, xosc_stable, pll_stable);
    assign pend_need_on = !src_is_stable(pend_q.src, irc_stable, xosc_stable, pll_stable);

    sysclk_req_filter u_filter (
        .req_valid (req_valid),
        .req       (req_in),
        .accept    (accept)
    );

    sysclk_ready_eval u_ready (
        .act             (act_q),
        .need_on         (need_on_q),
        .irc_stable      (irc_stable),
        .xosc_stable     (xosc_stable),
        .pll_stable      (pll_stable),
        .src_on_done     (src_on_done),
        .pll_on_done     (pll_on_done),
        .periph_off_done (periph_off_done),
        .ready           (ready)
    );

    sysclk_sel_decode #(.N_SRC(NUM_SRC)) u_sel (
        .cur_src (cur_src),
        .stby    (stby_q),
        .sel     (src_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            act_q     <= '0;
            pend_q    <= '0;
            pend_v_q  <= 1'b0;
            need_on_q <= 1'b0;
            stby_q    <= 1'b0;
            cur_src   <= SRC_IRC;
        end else if (state_q == ST_IDLE) begin
            if (accept) begin
                act_q     <= req_in;
                need_on_q <= req_need_on;
                state_q   <= ST_WAIT;
            end
        end else if (ready) begin
            if (act_q.mode == MD_STANDBY) begin
                stby_q <= 1'b1;
            end else begin
                cur_src <= act_q.src;
                stby_q  <= 1'b0;
            end
            if (pend_v_q) begin
                act_q     <= pend_q;
                need_on_q <= pend_need_on;
                pend_v_q  <= accept;
                if (accept)
                    pend_q <= req_in;
            end else if (accept) begin
                act_q     <= req_in;
                need_on_q <= req_need_on;
            end else begin
                state_q <= ST_IDLE;
            end
        end else if (accept) begin
            pend_q   <= req_in;
            pend_v_q <= 1'b1;
        end
    end

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cur_src == SRC_IRC) && !busy);

    // R2: internal RC codes only adopted when that oscillator was stable
    assert_irc_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_src != $past(cur_src)) && (cur_src == SRC_IRC || cur_src == SRC_IRC_DIV)
        |-> $past(irc_stable));

    // R3: crystal codes only adopted when the crystal was stable
    assert_xosc_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_src != $past(cur_src)) && (cur_src == SRC_XOSC || cur_src == SRC_XOSC_DIV)
        |-> $past(xosc_stable));

    // R4: PLL adopted only with lock and switch-on handshake
    assert_pll_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_src != $past(cur_src)) && (cur_src == SRC_PLL)
        |-> $past(pll_stable && pll_on_done));

    // R5: no switch without the peripheral disable handshake
    assert_periph_done_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_src != $past(cur_src)) |-> $past(periph_off_done));

    // R7: status frozen while waiting
    assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !ready) |=> $stable(cur_src));

    // R11: reserved codes never start a switch
    assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_mode != MD_STANDBY && req_src > SRC_PLL && req_src < SRC_OFF)
        |=> !busy && $stable(cur_src));

    // R12: standby forces every select low
    assert_standby_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && ready && act_q.mode == MD_STANDBY) |=> (src_sel == '0));

endmodule

// File: tb/sysclk_switch_ctrl_tb.sv
module sysclk_switch_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [3:0] req_src;
    logic [2:0] req_mode;
    logic       irc_stable, xosc_stable, pll_stable;
    logic       src_on_done, pll_on_done, periph_off_done;
    logic [3:0] cur_src;
    logic [4:0] src_sel;
    logic       busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit rnd_on = 0;

    // expectation model state, derived from the requirements
    logic [3:0] m_cur;
    logic       m_busy, m_stby, m_need, m_pv;
    logic [3:0] m_asrc, m_psrc;
    logic [2:0] m_amode, m_pmode;

    always #4 clk = ~clk; // 125 MHz

    sysclk_switch_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
        .req_mode(req_mode), .irc_stable(irc_stable), .xosc_stable(xosc_stable),
        .pll_stable(pll_stable), .src_on_done(src_on_done), .pll_on_done(pll_on_done),
        .periph_off_done(periph_off_done), .cur_src(cur_src), .src_sel(src_sel),
        .busy(busy)
    );

    function automatic bit legal(input logic [3:0] s, input logic [2:0] m);
        if (m == 3'd7) return 1;
        if (s <= 4'd4) return 1;
        if (s == 4'd15) return (m == 3'd6) || (m == 3'd1);
        return 0;
    endfunction

    function automatic bit stab(input logic [3:0] s);
        if (s <= 4'd1) return irc_stable;
        if (s <= 4'd3) return xosc_stable;
        if (s == 4'd4) return pll_stable;
        return 1;
    endfunction

    function automatic bit rdy();
        if (m_amode == 3'd7) return 1;
        return periph_off_done && stab(m_asrc) && (!m_need || src_on_done)
               && (m_asrc != 4'd4 || pll_on_done);
    endfunction

    function automatic logic [4:0] exp_sel(input logic [3:0] c, input logic s);
        if (s || c > 4'd4) return 5'd0;
        return 5'd1 << c;
    endfunction

    task automatic model_tick();
        bit acc;
        acc = req_valid && legal(req_src, req_mode);
        if (!m_busy) begin
            if (acc) begin
                m_asrc = req_src; m_amode = req_mode; m_need = !stab(req_src); m_busy = 1;
            end
        end else if (rdy()) begin
            if (m_amode == 3'd7) m_stby = 1;
            else begin m_cur = m_asrc; m_stby = 0; end
            if (m_pv) begin
                m_asrc = m_psrc; m_amode = m_pmode; m_need = !stab(m_psrc);
                m_pv = acc;
                if (acc) begin m_psrc = req_src; m_pmode = req_mode; end
            end else if (acc) begin
                m_asrc = req_src; m_amode = req_mode; m_need = !stab(req_src);
            end else m_busy = 0;
        end else if (acc) begin
            m_psrc = req_src; m_pmode = req_mode; m_pv = 1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        if (rnd_on) begin
            chk("R8 status", cur_src, m_cur);
            chk("R8 busy", busy, m_busy);
            chk("R12 select", src_sel, exp_sel(m_cur, m_stby));
        end
    endtask

    task automatic req_step(input logic [3:0] s, input logic [2:0] m);
        req_valid = 1; req_src = s; req_mode = m;
        step();
        req_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; req_valid = 0; req_src = 0; req_mode = 3'd4;
        irc_stable = 0; xosc_stable = 0; pll_stable = 0;
        src_on_done = 0; pll_on_done = 0; periph_off_done = 0;
        m_cur = 0; m_busy = 0; m_stby = 0; m_need = 0; m_pv = 0;
        m_asrc = 0; m_psrc = 0; m_amode = 0; m_pmode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 cur", cur_src, 0);
        chk("R1 busy", busy, 0);
        chk("R1 sel", src_sel, 5'b00001);

        // PLL with lock then handshake
        req_step(4'd4, 3'd4);
        chk("R8 busy rise", busy, 1);
        periph_off_done = 1; src_on_done = 1; pll_stable = 1; pll_on_done = 0;
        step();
        chk("R4 wait pll_on_done", cur_src, 0);
        chk("R7 sel held", src_sel, 5'b00001);
        pll_on_done = 1;
        step();
        chk("R4 cur", cur_src, 4);
        chk("R8 busy fall", busy, 0);
        chk("R4 sel", src_sel, 5'b10000);

        // peripheral handshake gating
        xosc_stable = 1; src_on_done = 0; periph_off_done = 0;
        req_step(4'd2, 3'd4);
        step();
        chk("R5 blocked", cur_src, 4);
        periph_off_done = 1;
        step();
        chk("R5 done", cur_src, 2);

        // switch-on need captured at take-up
        irc_stable = 0; src_on_done = 0;
        req_step(4'd0, 3'd3);
        src_on_done = 1;
        step();
        chk("R2 irc not stable", cur_src, 2);
        src_on_done = 0; irc_stable = 1;
        step();
        chk("R6 wait src_on_done", cur_src, 2);
        src_on_done = 1;
        step();
        chk("R2 cur", cur_src, 0);

        // crystal divided
        xosc_stable = 0;
        req_step(4'd3, 3'd4);
        step();
        chk("R3 blocked", cur_src, 0);
        xosc_stable = 1;
        step();
        chk("R3 cur", cur_src, 3);

        // disable in wrong mode
        req_step(4'd15, 3'd4);
        chk("R10 busy", busy, 0);
        step();
        chk("R10 cur", cur_src, 3);

        // reserved code
        req_step(4'd9, 3'd2);
        chk("R11 busy", busy, 0);
        step();
        chk("R11 cur", cur_src, 3);

        // disable in stop
        req_step(4'd15, 3'd6);
        chk("R9 busy", busy, 1);
        step();
        chk("R9 cur", cur_src, 15);
        chk("R9 sel", src_sel, 0);

        // standby
        req_step(4'd0, 3'd4);
        step();
        chk("R12 back on RC", src_sel, 5'b00001);
        req_step(4'd2, 3'd7);
        step();
        chk("R12 cur kept", cur_src, 0);
        chk("R12 sel low", src_sel, 0);
        req_step(4'd1, 3'd4);
        step();
        chk("R12 exit cur", cur_src, 1);
        chk("R12 exit sel", src_sel, 5'b00010);

        // queued request
        periph_off_done = 0;
        req_step(4'd2, 3'd4);
        req_step(4'd4, 3'd4);
        chk("R13 busy queued", busy, 1);
        chk("R13 cur held", cur_src, 1);
        periph_off_done = 1;
        step();
        chk("R13 first served", cur_src, 2);
        chk("R13 still busy", busy, 1);
        step();
        chk("R13 queued served", cur_src, 4);
        chk("R13 busy fall", busy, 0);

        // random phase checked against the model
        rnd_on = 1;
        for (int i = 0; i < 2000; i++) begin
            int r;
            req_valid = ($urandom_range(0, 3) == 0);
            r = $urandom_range(0, 9);
            req_src = (r < 7) ? 4'($urandom_range(0, 4)) : (r < 9 ? 4'd15 : 4'($urandom_range(5, 14)));
            req_mode = ($urandom_range(0, 9) == 0) ? 3'd7 : 3'($urandom_range(0, 6));
            irc_stable      = ($urandom_range(0, 3) != 0);
            xosc_stable     = ($urandom_range(0, 3) != 0);
            pll_stable      = ($urandom_range(0, 3) != 0);
            src_on_done     = ($urandom_range(0, 3) != 0);
            pll_on_done     = ($urandom_range(0, 3) != 0);
            periph_off_done = ($urandom_range(0, 3) != 0);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule